// File: doc/BRIEF.md
# Asymmetric True Dual-Port RAM

A synchronous memory with two independent ports that share a single storage array but see it at different word widths. The narrow port reads and writes single bytes over 256 locations. The wide port reads and writes 16-bit words over 128 locations. Both ports act on the rising edge of one common clock, and each has its own address, write data, write enable and registered read data.

The block converts between narrow and wide addressing internally. The array is held as two byte-lane banks. A wide word covers two adjacent narrow addresses. A narrow write touches only the lane chosen by the low address bit. The block suits a producer and a consumer that naturally work at different widths, such as a byte stream packed into half-words.

Top module: `asym_dp_ram`

## Requirements
- R1: The narrow port is NARROW_W (8) bits wide and addresses NARROW_DEPTH (256) locations with an 8-bit address.
- R2: The wide port is 2*NARROW_W (16) bits wide and addresses NARROW_DEPTH/2 (128) locations with a 7-bit address.
- R3: Wide word w holds narrow byte 2w in bits [7:0] and narrow byte 2w+1 in bits [15:8]. Data written through either port is visible through the other.
- R4: A narrow write to address a changes only byte lane a[0] of wide word a[7:1]. The other lane keeps its value.
- R5: On either port, a high write enable stores that port's write data at its address on the clock edge. Otherwise the port reads.
- R6: Read data is registered and appears on the first rising edge after the address is presented with write enable low.
- R7: A port's read data output keeps its previous value across every cycle in which that port writes.
- R8: When both ports write the same wide word in one cycle, the wide port's data wins for both bytes of that word.
- R9: When both ports write different wide words in one cycle, both writes take effect.
- R10: When one port reads a location in the same cycle that the other port writes it, the read returns the contents from before the write.
- R11: While rst_ni is low, both read data outputs are zero. The array contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Common clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the read registers |
| a_addr_i | input | 8 | Narrow port byte address |
| a_wdata_i | input | 8 | Narrow port write data |
| a_we_i | input | 1 | Narrow port write enable |
| a_rdata_o | output | 8 | Narrow port registered read data |
| b_addr_i | input | 7 | Wide port word address |
| b_wdata_i | input | 16 | Wide port write data |
| b_we_i | input | 1 | Wide port write enable |
| b_rdata_o | output | 16 | Wide port registered read data |

## Verification
The array is first filled through the wide port and read back through the narrow port. This separates a correct lane mapping from a swapped one. Directed cycles then cover the following cases:
- Adjacent narrow writes followed by a wide read, which exposes lane ordering.
- A same-word dual write, which shows which port has priority.
- A split-word dual write, which shows both writes landing.
- A read in the same cycle as a write on the other port, which distinguishes old data from write-through data.

Long random mixed traffic then runs on a narrowed address range, so that collisions and output holds during writes occur often. Every registered read is compared against a byte-array shadow model.

// File: rtl/asym_ram_pkg.sv
package asym_ram_pkg;
  // wide word holds this many narrow bytes
  localparam int unsigned RATIO = 2;
  localparam int unsigned LANE_BITS = $clog2(RATIO);
endpackage

// File: rtl/asym_lane_bank.sv
module asym_lane_bank #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 128,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_wr_i,
  input  logic          a_rd_i,
  input  logic [IW-1:0] a_idx_i,
  input  logic [W-1:0]  a_data_i,
  input  logic          b_wr_i,
  input  logic          b_rd_i,
  input  logic [IW-1:0] b_idx_i,
  input  logic [W-1:0]  b_data_i,
  output logic [W-1:0]  a_q_o,
  output logic [W-1:0]  b_q_o
);
  logic [W-1:0] mem [DEPTH];

  // later assignment wins: wide port has priority on collision
  always_ff @(posedge clk_i) begin
    if (a_wr_i) mem[a_idx_i] <= a_data_i;
    if (b_wr_i) mem[b_idx_i] <= b_data_i;
  end

  // nonblocking reads see pre-write contents
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q_o <= '0;
      b_q_o <= '0;
    end else begin
      if (a_rd_i) a_q_o <= mem[a_idx_i];
      if (b_rd_i) b_q_o <= mem[b_idx_i];
    end
  end

  // R8: wide data wins on a same-word collision
  p_b_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_wr_i && b_wr_i && a_idx_i == b_idx_i) |=> (mem[$past(b_idx_i)] == $past(b_data_i)));

  // R5: a lone narrow-lane write lands
  p_a_lands_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_wr_i && !b_wr_i) |=> (mem[$past(a_idx_i)] == $past(a_data_i)));
endmodule

// File: rtl/asym_narrow_sel.sv
module asym_narrow_sel
  import asym_ram_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_i,
  input  logic [LANE_BITS-1:0] lane_i,
  input  logic [W-1:0]         lane_q_i [RATIO],
  output logic [W-1:0]         data_o
);
  logic [LANE_BITS-1:0] lane_q;

  // lane choice follows the data registers: updated on reads only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lane_q <= '0;
    else if (rd_i) lane_q <= lane_i;
  end

  assign data_o = lane_q_i[lane_q];
endmodule

// File: rtl/asym_dp_ram.sv
module asym_dp_ram
  import asym_ram_pkg::*;
#(
  parameter int unsigned NARROW_W     = 8,
  parameter int unsigned NARROW_DEPTH = 256,
  localparam int unsigned WIDE_W      = NARROW_W * RATIO,
  localparam int unsigned WIDE_DEPTH  = NARROW_DEPTH / RATIO,
  localparam int unsigned NAW         = $clog2(NARROW_DEPTH),
  localparam int unsigned WAW         = $clog2(WIDE_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NAW-1:0]    a_addr_i,
  input  logic [NARROW_W-1:0] a_wdata_i,
  input  logic              a_we_i,
  output logic [NARROW_W-1:0] a_rdata_o,
  input  logic [WAW-1:0]    b_addr_i,
  input  logic [WIDE_W-1:0] b_wdata_i,
  input  logic              b_we_i,
  output logic [WIDE_W-1:0] b_rdata_o
);
  logic [WAW-1:0]       a_word;
  logic [LANE_BITS-1:0] a_lane;
  logic [RATIO-1:0]     lane_wr_a;
  logic [NARROW_W-1:0]  lane_qa [RATIO];
  logic [NARROW_W-1:0]  lane_qb [RATIO];

  assign a_word = a_addr_i[NAW-1:LANE_BITS];
  assign a_lane = a_addr_i[LANE_BITS-1:0];

  for (genvar l = 0; l < RATIO; l++) begin : g_lane
    assign lane_wr_a[l] = a_we_i && (a_lane == LANE_BITS'(l));

    asym_lane_bank #(
      .W     (NARROW_W),
      .DEPTH (WIDE_DEPTH)
    ) i_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .a_wr_i   (lane_wr_a[l]),
      .a_rd_i   (!a_we_i),
      .a_idx_i  (a_word),
      .a_data_i (a_wdata_i),
      .b_wr_i   (b_we_i),
      .b_rd_i   (!b_we_i),
      .b_idx_i  (b_addr_i),
      .b_data_i (b_wdata_i[l*NARROW_W +: NARROW_W]),
      .a_q_o    (lane_qa[l]),
      .b_q_o    (lane_qb[l])
    );

    assign b_rdata_o[l*NARROW_W +: NARROW_W] = lane_qb[l];
  end

  asym_narrow_sel #(
    .W (NARROW_W)
  ) i_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (!a_we_i),
    .lane_i   (a_lane),
    .lane_q_i (lane_qa),
    .data_o   (a_rdata_o)
  );

  // R4: a narrow write selects at most one lane
  always_comb begin
    p_one_lane_r4: assert ($onehot0(lane_wr_a));
  end

  // R7: outputs hold while their port writes
  p_a_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_we_i |=> $stable(a_rdata_o));
  p_b_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_we_i |=> $stable(b_rdata_o));
endmodule

// File: tb/test_asym_dp_ram.sv
`timescale 1ns/1ps
module test_asym_dp_ram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  a_addr = '0;
  logic [7:0]  a_wdata = '0;
  logic        a_we = 1'b0;
  logic [7:0]  a_rdata;
  logic [6:0]  b_addr = '0;
  logic [15:0] b_wdata = '0;
  logic        b_we = 1'b0;
  logic [15:0] b_rdata;

  always #4 clk = ~clk; // 125 MHz

  asym_dp_ram i_asym_dp_ram (
    .clk_i(clk), .rst_ni(rst_n),
    .a_addr_i(a_addr), .a_wdata_i(a_wdata), .a_we_i(a_we), .a_rdata_o(a_rdata),
    .b_addr_i(b_addr), .b_wdata_i(b_wdata), .b_we_i(b_we), .b_rdata_o(b_rdata)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [7:0] shadow [256];
  logic [7:0]  last_a;
  logic [15:0] last_b;
  bit known_a = 1'b0;
  bit known_b = 1'b0;

  // scoreboard queues: due cycle, expected value, requirement tag
  int          qa_due[$];
  logic [7:0]  qa_val[$];
  string       qa_tag[$];
  int          qb_due[$];
  logic [15:0] qb_val[$];
  string       qb_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    while (qa_due.size() > 0 && qa_due[0] == cyc) begin
      logic [7:0] e;
      string t;
      e = qa_val.pop_front();
      t = qa_tag.pop_front();
      void'(qa_due.pop_front());
      total++;
      if (a_rdata !== e) begin
        bad++;
        $display("FAIL %s narrow read: got %h expected %h", t, a_rdata, e);
      end
    end
    while (qb_due.size() > 0 && qb_due[0] == cyc) begin
      logic [15:0] e;
      string t;
      e = qb_val.pop_front();
      t = qb_tag.pop_front();
      void'(qb_due.pop_front());
      total++;
      if (b_rdata !== e) begin
        bad++;
        $display("FAIL %s wide read: got %h expected %h", t, b_rdata, e);
      end
    end
  end

  // driver: one cycle of traffic, expectations from the shadow before update
  task automatic step(input bit awe, input logic [7:0] aa, input logic [7:0] ad,
                      input bit bwe, input logic [6:0] ba, input logic [15:0] bd,
                      input bit chk, input string tag);
    @(posedge clk); #2;
    a_we = awe; a_addr = aa; a_wdata = ad;
    b_we = bwe; b_addr = ba; b_wdata = bd;
    if (!awe) begin
      last_a = shadow[aa];
      known_a = 1'b1;
    end
    if (!bwe) begin
      last_b = {shadow[{ba, 1'b1}], shadow[{ba, 1'b0}]};
      known_b = 1'b1;
    end
    if (chk && known_a) begin
      qa_due.push_back(cyc + 1); qa_val.push_back(last_a); qa_tag.push_back(tag);
    end
    if (chk && known_b) begin
      qb_due.push_back(cyc + 1); qb_val.push_back(last_b); qb_tag.push_back(tag);
    end
    if (awe) shadow[aa] = ad;
    if (bwe) begin
      shadow[{ba, 1'b0}] = bd[7:0];
      shadow[{ba, 1'b1}] = bd[15:8];
    end
  endtask

  task automatic idle_read(input logic [7:0] aa, input logic [6:0] ba, input string tag);
    step(1'b0, aa, 8'h00, 1'b0, ba, 16'h0000, 1'b1, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #6;
    // R11: reset state of read outputs
    total++;
    if (a_rdata !== 8'h00) begin
      bad++;
      $display("FAIL R11 narrow reset: got %h expected 00", a_rdata);
    end
    total++;
    if (b_rdata !== 16'h0000) begin
      bad++;
      $display("FAIL R11 wide reset: got %h expected 0000", b_rdata);
    end
    rst_n = 1'b1;

    // R2 fill the array through the wide port
    for (int w = 0; w < 128; w++)
      step(1'b0, 8'h00, 8'h00, 1'b1, 7'(w), {8'(w) ^ 8'hA5, 8'(w) ^ 8'h3C}, 1'b0, "R2");
    known_a = 1'b0;
    known_b = 1'b0;
    // R1 R3 read back every byte through the narrow port
    for (int a = 0; a < 256; a++) idle_read(8'(a), 7'(a >> 1), "R3");

    // R4 R3: adjacent narrow writes, wide read shows lane order
    step(1'b1, 8'h04, 8'h11, 1'b0, 7'd9, 16'h0, 1'b1, "R7");
    step(1'b1, 8'h05, 8'h22, 1'b0, 7'd9, 16'h0, 1'b1, "R7");
    idle_read(8'h04, 7'd2, "R3");
    step(1'b1, 8'h05, 8'h99, 1'b0, 7'd2, 16'h0, 1'b1, "R7");
    idle_read(8'h04, 7'd2, "R4");
    idle_read(8'h05, 7'd2, "R6");

    // R8: same-word collision, wide data wins
    step(1'b1, 8'h06, 8'hAA, 1'b1, 7'd3, 16'h5566, 1'b1, "R7");
    idle_read(8'h06, 7'd3, "R8");
    idle_read(8'h07, 7'd3, "R8");

    // R9: different words, both writes land
    step(1'b1, 8'h08, 8'hC3, 1'b1, 7'd10, 16'hBEEF, 1'b1, "R7");
    idle_read(8'h08, 7'd10, "R9");
    idle_read(8'h14, 7'd4, "R9");

    // R10: cross-port read during write returns old contents
    step(1'b0, 8'h20, 8'h00, 1'b1, 7'd16, 16'h7788, 1'b1, "R10");
    step(1'b1, 8'h22, 8'h5D, 1'b0, 7'd17, 16'h0, 1'b1, "R10");
    idle_read(8'h21, 7'd17, "R10");

    // R5 R6 R7: random mixed traffic on a narrow window to force collisions
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] aa;
      logic [6:0] ba;
      aa = 8'($urandom_range(0, 15)) + ((i % 4 == 0) ? 8'($urandom_range(0, 240)) : 8'h0);
      ba = 7'($urandom_range(0, 7));
      step(($urandom % 3) == 0, aa, 8'($urandom),
           ($urandom % 3) == 0, ba, 16'($urandom), 1'b1, "R5");
    end
    for (int a = 0; a < 16; a++) idle_read(8'(a), 7'(a), "R5");

    step(1'b0, 8'h00, 8'h00, 1'b0, 7'd0, 16'h0, 1'b0, "R6");
    repeat (3) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule